// File: doc/BRIEF.md
# LCD Common Scan Timing Controller

This block produces the common-line scan timing for a multiplexed segment LCD. It takes a base clock and one byte-wide control register on a plain write/read bus. It divides the base clock by a programmable power of two and steps through the active common lines at that rate. The number of active common lines follows a runtime duty field. The block reports the active common line as an index and as a one-hot select. It pulses a strobe once per frame, which is one full pass over the active commons.

In the reduced duties, the upper common pins are not used as commons. The block drives pin-function select bits that hand those pins to the segment driver as extra segment lines, always in the same order. Scanning depends only on the base clock, so it keeps going with no bus activity at all. The voltage booster enable is stored in the register and passed to an output pin, and it has no effect on timing. The base clock is the block's `clk`.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: The control register is at byte address 0xF1. Its fields are bit 5 scan enable, bit 4 booster enable, bits 3:2 duty and bits 1:0 rate. Reading 0xF1 returns bits 7:6 as zero. A read of any other address returns 0x00, and a write to any other address changes nothing.
- R2: After reset the register reads 0x00. Scanning is then disabled, the booster is off, the duty is four commons and the rate is divide-by-32.
- R3: Rate code 0, 1, 2 or 3 makes the common index advance once every 32, 64, 128 or 256 base clock cycles respectively.
- R4: Duty code 00, 01, 10 or 11 selects 4, 3, 2 or 1 active commons. The index counts up from 0 to (active commons − 1) and then wraps to 0.
- R5: `frame_strobe` is high for exactly one cycle each time the index wraps to 0. Successive strobes are therefore (rate divisor × active commons) cycles apart, for all 16 duty/rate combinations.
- R6: While scanning, `com_sel` has exactly one bit set, which is bit `com_idx`.
- R7: While scan enable is 0, `com_sel` is 0, `com_idx` is 0 and `frame_strobe` is 0. After a write sets enable, common 0 is active for the first full rate period. The first strobe comes (divisor × commons) cycles after the write edge.
- R8: `pin_seg_sel` bit 0 gives common 3 to segment 34, bit 1 gives common 2 to segment 35, and bit 2 gives common 1 to segment 36. The number of bits set equals the duty code, filled from bit 0 upward.
- R9: A register write that changes the duty or rate field restarts the scan at common 0 with an empty prescaler, starting from that write edge. A write that leaves both fields unchanged does not disturb the scan phase.
- R10: `boost_en` follows register bit 4 and has no effect on scan timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; all timing derives from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register bus address |
| bus_wdata | input | 8 | Register bus write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| disp_en | output | 1 | Scan enable bit of the register |
| boost_en | output | 1 | Booster enable bit of the register |
| com_sel | output | 4 | One-hot active common line |
| com_idx | output | 2 | Index of the active common line |
| frame_strobe | output | 1 | One-cycle pulse at each frame wrap |
| pin_seg_sel | output | 3 | Common pins reassigned as segment lines |

## Verification
A wrong prescaler count shows within one rate period: `com_sel` moves to the next common early or late, and an exact per-cycle model of the index catches it. A wrong wrap limit for the duty shows within one frame. Either an index past the last active common appears on `com_sel`, or the gap between strobes differs from divisor × commons. The gap is measured for every duty/rate pair. A missed or spurious restart shifts the phase of the whole following sequence, so the first comparison after the write flags it. A random mix of writes, including ones that leave the fields unchanged, exposes such faults at once.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  localparam int NUM_COM = 4;
  localparam int IDX_W   = 2;

  typedef enum logic [1:0] {
    DUTY_FOUR   = 2'b00,
    DUTY_THREE  = 2'b01,
    DUTY_TWO    = 2'b10,
    DUTY_SINGLE = 2'b11
  } duty_e;

  typedef struct packed {
    logic        scan_on;
    logic        boost_on;
    duty_e       duty;
    logic [1:0]  rate;
  } ctrl_t;

  // highest common index that is scanned for a duty code
  function automatic logic [IDX_W-1:0] last_common(input duty_e d);
    return IDX_W'(NUM_COM - 1) - IDX_W'(d);
  endfunction

endpackage

// File: rtl/lcd_ctrl_regs.sv
module lcd_ctrl_regs
  import lcd_scan_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  REG_ADDR = 8'hF1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  output logic [DATA_W-1:0] bus_rdata,
  output ctrl_t             ctrl,
  output logic              restart
);

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int TIME_W = 4; // duty + rate bits, the low part of ctrl_t

  logic  hit;
  ctrl_t nxt;

  assign hit = (bus_addr == ADDR_W'(REG_ADDR));
  assign nxt = ctrl_t'(bus_wdata[CTRL_W-1:0]);

  // a change of duty or rate restarts the scan on the same edge
  assign restart = bus_wr && hit &&
                   (bus_wdata[TIME_W-1:0] != ctrl[TIME_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (bus_wr && hit) begin
      ctrl <= nxt;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      bus_rdata[CTRL_W-1:0] = ctrl;
    end
  end

endmodule

// File: rtl/lcd_prescaler.sv
module lcd_prescaler #(
  parameter int BASE_LOG2 = 5,
  parameter int RATE_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clear,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);

  localparam int RATE_N = 1 << RATE_W;
  localparam int CNT_W  = BASE_LOG2 + RATE_N - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] term [RATE_N];

  for (genvar g = 0; g < RATE_N; g++) begin : g_term
    localparam int unsigned TERM = (1 << (BASE_LOG2 + g)) - 1;
    assign term[g] = TERM[CNT_W-1:0];
  end

  assign tick = run && (cnt == term[rate]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || clear || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/lcd_com_counter.sv
module lcd_com_counter
  import lcd_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic             tick,
  input  duty_e            duty,
  output logic [IDX_W-1:0] idx,
  output logic             wrap_q
);

  logic [IDX_W-1:0] last;
  logic             at_last;

  assign last    = last_common(duty);
  assign at_last = (idx >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '0;
      wrap_q <= 1'b0;
    end else if (!run || clear) begin
      idx    <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= tick && at_last;
      if (tick) begin
        idx <= at_last ? '0 : idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lcd_pin_map.sv
module lcd_pin_map
  import lcd_scan_pkg::*;
(
  input  logic               run,
  input  duty_e              duty,
  input  logic [IDX_W-1:0]   idx,
  output logic [NUM_COM-1:0] com_sel,
  output logic [NUM_COM-2:0] seg_sel
);

  logic [IDX_W-1:0] last;
  assign last = last_common(duty);

  for (genvar g = 0; g < NUM_COM; g++) begin : g_com
    assign com_sel[g] = run && (idx == IDX_W'(g));
  end

  // bit g hands common (NUM_COM-1-g) to the segment driver
  for (genvar g = 0; g < NUM_COM - 1; g++) begin : g_seg
    assign seg_sel[g] = (IDX_W'(NUM_COM - 1 - g) > last);
  end

endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
#(
  parameter int          BASE_LOG2 = 5,
  parameter logic [7:0]  REG_ADDR  = 8'hF1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         bus_addr,
  input  logic [7:0]         bus_wdata,
  input  logic               bus_wr,
  output logic [7:0]         bus_rdata,
  output logic               disp_en,
  output logic               boost_en,
  output logic [NUM_COM-1:0] com_sel,
  output logic [IDX_W-1:0]   com_idx,
  output logic               frame_strobe,
  output logic [NUM_COM-2:0] pin_seg_sel
);

  ctrl_t            ctrl_q;
  logic             cfg_restart;
  logic             pre_tick;
  logic [IDX_W-1:0] idx_q;
  logic             wrap_q;

  lcd_ctrl_regs #(
    .ADDR_W   (8),
    .DATA_W   (8),
    .REG_ADDR (REG_ADDR)
  ) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .ctrl      (ctrl_q),
    .restart   (cfg_restart)
  );

  lcd_prescaler #(
    .BASE_LOG2 (BASE_LOG2),
    .RATE_W    (2)
  ) pre_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (ctrl_q.scan_on),
    .clear (cfg_restart),
    .rate  (ctrl_q.rate),
    .tick  (pre_tick)
  );

  lcd_com_counter cnt_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (ctrl_q.scan_on),
    .clear  (cfg_restart),
    .tick   (pre_tick),
    .duty   (ctrl_q.duty),
    .idx    (idx_q),
    .wrap_q (wrap_q)
  );

  lcd_pin_map map_i (
    .run     (ctrl_q.scan_on),
    .duty    (ctrl_q.duty),
    .idx     (idx_q),
    .com_sel (com_sel),
    .seg_sel (pin_seg_sel)
  );

  assign disp_en      = ctrl_q.scan_on;
  assign boost_en     = ctrl_q.boost_on;
  assign com_idx      = ctrl_q.scan_on ? idx_q : '0;
  assign frame_strobe = ctrl_q.scan_on && wrap_q;

endmodule

// File: rtl/lcd_scan_ctrl_chk.sv
module lcd_scan_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] ctrl,
  input logic       restart,
  input logic       tick,
  input logic [7:0] bus_rdata,
  input logic       disp_en,
  input logic [3:0] com_sel,
  input logic [1:0] com_idx,
  input logic       frame_strobe,
  input logic [2:0] pin_seg_sel
);

  logic [1:0] last;
  assign last = 2'd3 - ctrl[3:2];

  // R1: unimplemented bits never read as one
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[7:6] == 2'b00);

  // R4: index stays inside the active commons
  a_r4_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |-> (com_idx <= last));

  // R4: index only moves on a prescaled tick or a restart
  a_r4_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && $past(disp_en) && !$past(restart) && !$past(tick))
      |-> $stable(com_idx));

  // R5: strobe marks a wrap to common 0 after a tick
  a_r5_strobe_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |-> (com_idx == 2'd0) && $past(tick));

  // R6: exactly one common selected while scanning
  a_r6_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |-> ($countones(com_sel) == 1) && com_sel[com_idx]);

  // R7: everything idle while disabled
  a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |-> (com_sel == 4'd0) && (com_idx == 2'd0) && !frame_strobe);

  // R8: one reassigned pin per dropped common
  a_r8_pin_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pin_seg_sel) == int'(ctrl[3:2]));

  // R9: a restart lands the scan on common 0 with no strobe
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && ctrl[5]) |=> (com_idx == 2'd0) && !frame_strobe);

endmodule

bind lcd_scan_ctrl lcd_scan_ctrl_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctrl         (ctrl_q),
  .restart      (cfg_restart),
  .tick         (pre_tick),
  .bus_rdata    (bus_rdata),
  .disp_en      (disp_en),
  .com_sel      (com_sel),
  .com_idx      (com_idx),
  .frame_strobe (frame_strobe),
  .pin_seg_sel  (pin_seg_sel)
);

// File: tb/lcd_scan_ctrl_tb.sv
`timescale 1ns/1ps
module lcd_scan_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_rdata;
  logic       disp_en, boost_en, frame_strobe;
  logic [3:0] com_sel;
  logic [1:0] com_idx;
  logic [2:0] pin_seg_sel;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int base = 0;
  logic [5:0] m_ctrl = 6'd0;
  int strb_last = -1;
  int strb_prev = -1;
  int strb_cnt = 0;

  always #2.5 clk = ~clk;

  lcd_scan_ctrl dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_wr       (bus_wr),
    .bus_rdata    (bus_rdata),
    .disp_en      (disp_en),
    .boost_en     (boost_en),
    .com_sel      (com_sel),
    .com_idx      (com_idx),
    .frame_strobe (frame_strobe),
    .pin_seg_sel  (pin_seg_sel)
  );

  function automatic int f_div(input logic [1:0] r);
    return 32 << r;
  endfunction

  function automatic int f_ncom(input logic [1:0] d);
    return 4 - int'(d);
  endfunction

  function automatic int f_pins(input logic [1:0] d);
    return (1 << d) - 1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'hF1) begin
      if (d[5] && ((d[3:0] != m_ctrl[3:0]) || !m_ctrl[5])) base = cyc;
      m_ctrl = d[5:0];
    end
  endtask

  // one clock: apply the write seen at the edge, then compare at the negedge
  task automatic step();
    int k, dv, n, e_idx, e_strb;
    @(posedge clk);
    cyc++;
    if (bus_wr) model_write(bus_addr, bus_wdata);
    @(negedge clk);
    bus_wr = 1'b0;
    if (!m_ctrl[5]) begin
      e_idx = 0; e_strb = 0;
    end else begin
      k = cyc - base;
      dv = f_div(m_ctrl[1:0]);
      n = f_ncom(m_ctrl[3:2]);
      e_idx = (k / dv) % n;
      e_strb = (k > 0 && (k % (dv * n)) == 0) ? 1 : 0;
    end
    chk("R4", int'(com_idx), e_idx);
    chk("R6", int'(com_sel), m_ctrl[5] ? (1 << e_idx) : 0);
    chk("R5", int'(frame_strobe), e_strb);
    chk("R8", int'(pin_seg_sel), f_pins(m_ctrl[3:2]));
    chk("R10", int'(boost_en), int'(m_ctrl[4]));
    if (frame_strobe) begin
      strb_prev = strb_last;
      strb_last = cyc;
      strb_cnt++;
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input int exp);
    bus_addr = a;
    #0.5;
    chk(tag, int'(bus_rdata), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int w, period;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2: reset state
    rd("R2", 8'hF1, 0);
    chk("R2", int'(com_sel), 0);
    chk("R7", int'(disp_en), 0);
    run(40);

    // R1: reserved bits, foreign address
    wr(8'hF1, 8'hDF);
    rd("R1", 8'hF1, 8'h1F);
    wr(8'hF0, 8'h3F);
    rd("R1", 8'hF1, 8'h1F);
    rd("R1", 8'hF0, 0);
    wr(8'hF1, 8'h00);
    run(5);

    // R3 R5 R7: all 16 duty/rate pairs, strobe spacing
    for (int d = 0; d < 4; d++) begin
      for (int r = 0; r < 4; r++) begin
        period = f_div(2'(r)) * f_ncom(2'(d));
        wr(8'hF1, 8'(32 | (d << 2) | r));
        w = cyc;
        strb_cnt = 0;
        while (strb_cnt < 2) step();
        chk("R7", strb_prev - w, period);
        chk("R5", strb_last - strb_prev, period);
        chk("R3", f_div(2'(r)), 32 << r);
      end
    end
    wr(8'hF1, 8'h00);
    run(10);

    // R9: unchanged fields keep phase; changed fields restart
    wr(8'hF1, 8'h25);
    run(100);
    wr(8'hF1, 8'h35);
    run(150);
    wr(8'hF0, 8'h00);
    run(60);
    wr(8'hF1, 8'h29);
    chk("R9", int'(com_idx), 0);
    run(300);
    // R7: disable then enable on consecutive cycles
    wr(8'hF1, 8'h09);
    wr(8'hF1, 8'h2C);
    run(200);

    // random mix of writes
    for (int i = 0; i < 60; i++) begin
      logic [7:0] a, d;
      a = ($urandom % 8 == 0) ? 8'($urandom) : 8'hF1;
      d = 8'($urandom);
      if ($urandom % 8 != 0) d[5] = 1'b1;
      if ($urandom % 4 == 0) d[3:0] = m_ctrl[3:0];
      wr(a, d);
      run(1 + ($urandom % 1200));
    end
    rd("R1", 8'hF1, int'(m_ctrl));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule